// File: doc/BRIEF.md
# Register-Mapped SPI Master with Byte FIFOs

This block is a serial peripheral interface controller that only ever acts as the bus master. Software reaches it through a 32-bit register port with single-cycle read and write strobes. Bytes written to the transmit data register queue in a transmit FIFO. Whenever the controller is enabled, set to master operation and not held for manual start, the serial engine takes the oldest queued byte and shifts it out most significant bit first. It captures one byte from the input line for every byte it sends and queues that byte in a receive FIFO. Software drains the receive FIFO by reading the receive data register.

The control register sets the clock polarity, the clock phase and a 3-bit divisor code. The serial clock half period is 2^code reference cycles, so the full period is 2^(code+1) cycles. The control register also holds a 4-bit chip-select field that drives the active-low select pins directly. Software picks target 0 with a field of xxx0, target 1 with xx01 and target 2 with x011; all ones selects no target. Two overflow events latch into the interrupt status register. A mask, set through one register and cleared through another, gates the status bits onto a single interrupt line.

Register offsets: control 0x00, interrupt status 0x04, mask set 0x08, mask clear 0x0C, mask read 0x10, enable 0x14, delay 0x18 (plain storage), transmit data 0x1C, receive data 0x20.

Top module: `spi_fifo_master`

## Requirements
- R1: After reset, control reads 0x00003C00, status reads 0x00000004, the mask reads 0, `cs_n` is 4'b1111, `sclk` is 0 and `irq` is 0.
- R2: A byte starts shifting only when the transmit FIFO is non-empty, enable bit 0 (offset 0x14) is 1, control bit 0 (master) is 1 and control bit 15 (manual start) is 0. Otherwise `sclk` does not toggle and queued bytes stay queued.
- R3: During a byte, the time between consecutive `sclk` edges is 2^code reference cycles, where code is control bits [5:3].
- R4: When no byte is in flight, `sclk` rests at the level of control bit 1 (CPOL).
- R5: Each byte makes 16 `sclk` edges and is sent MSB first on `mosi`. With control bit 2 (CPHA) at 0, `mosi` is valid at and `miso` is captured on each edge that leaves the idle level. With CPHA at 1, this happens on each edge that returns to the idle level.
- R6: Each byte sent pushes the captured byte into the receive FIFO. A read of offset 0x20 returns the oldest byte in bits [7:0] and removes it.
- R7: `cs_n[3:0]` always equals control bits [13:10].
- R8: A write to 0x1C while the transmit FIFO is full is dropped and sets status bit 0. Status bit 2 reads 1 while the transmit FIFO is not full.
- R9: A byte received while the receive FIFO is full is discarded and sets status bit 1. Status bit 4 reads 1 while the receive FIFO holds data.
- R10: Writing a 1 to status bit 0 or bit 1 at offset 0x04 clears that latched bit. Writing 0 leaves it set.
- R11: Writing ones to 0x08 sets mask bits and writing ones to 0x0C clears them. The mask reads at 0x10, and `irq` is the OR of status bits [6:0] ANDed with the mask.
- R12: A write to 0x1C queues only bits [7:0] of the write data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (pops receive data at 0x20) |
| addr | input | 8 | Byte offset of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, combinational from `addr` |
| irq | output | 1 | Masked interrupt |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 4 | Active-low target selects |

## Verification
All four polarity and phase combinations are swept against divisor codes 0 to 3 and 7. `miso` is looped back from `mosi` either directly or inverted. The loopback shows whether captured data aligns with sent data. The inversion shows whether a stuck or ignored input is actually sampled. A monitor samples `mosi` on the edge each phase setting names and measures the spacing between edges. This tells the two phases apart, catches bit-order mistakes and catches divisor errors. A four-entry FIFO configuration is used so that full-FIFO drops on both sides, the sticky overflow bits, the mask and each blocking condition for auto-start are reached in a few bytes.

// File: rtl/spi_fm_pkg.sv
package spi_fm_pkg;
  localparam logic [7:0] OFS_CTRL = 8'h00;
  localparam logic [7:0] OFS_STS  = 8'h04;
  localparam logic [7:0] OFS_MSET = 8'h08;
  localparam logic [7:0] OFS_MCLR = 8'h0C;
  localparam logic [7:0] OFS_MASK = 8'h10;
  localparam logic [7:0] OFS_EN   = 8'h14;
  localparam logic [7:0] OFS_DLY  = 8'h18;
  localparam logic [7:0] OFS_TXD  = 8'h1C;
  localparam logic [7:0] OFS_RXD  = 8'h20;

  localparam int CB_MASTER = 0;
  localparam int CB_CPOL   = 1;
  localparam int CB_CPHA   = 2;
  localparam int CB_DIV_LO = 3;
  localparam int CB_CS_LO  = 10;
  localparam int CB_MSTART = 15;

  localparam int SB_TXOV = 0;
  localparam int SB_RXOV = 1;
  localparam int SB_TXNF = 2;
  localparam int SB_RXNE = 4;
  localparam int STS_W   = 7;

  localparam logic [15:0] CTRL_RST = 16'h3C00;

  // Number of reference cycles between two serial clock edges.
  function automatic int unsigned half_cycles(input int unsigned code);
    return 32'd1 << code;
  endfunction

  // An edge samples data when it leads with phase 0 or trails with phase 1.
  function automatic logic is_sample_edge(input logic leading, input logic cpha);
    return leading ^ cpha;
  endfunction
endpackage

// File: rtl/spi_fm_fifo.sv
module spi_fm_fifo #(
  parameter int DEPTH = 128,
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [WIDTH-1:0] din,
  input  logic             pop,
  output logic [WIDTH-1:0] head,
  output logic             full,
  output logic             empty
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_ptr, rd_ptr;
  logic [CW-1:0]    count;
  logic             do_push, do_pop;

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign head    = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/spi_fm_engine.sv
module spi_fm_engine
  import spi_fm_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [DATA_W-1:0] tx_byte,
  input  logic              cpol,
  input  logic              cpha,
  input  logic [DIV_W-1:0]  div_code,
  input  logic              miso,
  output logic              sclk,
  output logic              mosi,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rx_byte
);
  localparam int CNT_W   = 2 ** DIV_W;
  localparam int EDGES   = 2 * DATA_W;
  localparam int EDGE_W  = $clog2(EDGES);

  logic [CNT_W-1:0]  cnt, half_m1;
  logic [EDGE_W-1:0] edge_idx;
  logic [DATA_W-1:0] tx_sr, rx_sr;
  logic              sclk_int, out_bit;
  logic              tick, leading, sample_now, last_edge;

  assign half_m1    = CNT_W'(half_cycles(32'(div_code)) - 1);
  assign tick       = busy && (cnt == half_m1);
  assign leading    = !edge_idx[0];
  assign sample_now = is_sample_edge(leading, cpha);
  assign last_edge  = (edge_idx == EDGE_W'(EDGES - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      done     <= 1'b0;
      cnt      <= '0;
      edge_idx <= '0;
      sclk_int <= 1'b0;
      out_bit  <= 1'b0;
      tx_sr    <= '0;
      rx_sr    <= '0;
    end else begin
      done <= tick && last_edge;
      if (start && !busy) begin
        busy     <= 1'b1;
        cnt      <= '0;
        edge_idx <= '0;
        sclk_int <= 1'b0;
        tx_sr    <= cpha ? tx_byte : (tx_byte << 1);
        out_bit  <= cpha ? 1'b0 : tx_byte[DATA_W-1];
      end else if (busy) begin
        if (tick) begin
          cnt      <= '0;
          sclk_int <= ~sclk_int;
          edge_idx <= edge_idx + 1'b1;
          if (sample_now) begin
            rx_sr <= {rx_sr[DATA_W-2:0], miso};
          end else begin
            out_bit <= tx_sr[DATA_W-1];
            tx_sr   <= tx_sr << 1;
          end
          if (last_edge) busy <= 1'b0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  assign sclk    = sclk_int ^ cpol;
  assign mosi    = out_bit;
  assign rx_byte = rx_sr;
endmodule

// File: rtl/spi_fifo_master.sv
module spi_fifo_master
  import spi_fm_pkg::*;
#(
  parameter int FIFO_DEPTH = 128,
  parameter int DATA_W     = 8,
  parameter int DIV_W      = 3,
  parameter int CS_W       = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic        rd_en,
  input  logic [7:0]  addr,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  output logic        irq,
  output logic        sclk,
  output logic        mosi,
  input  logic        miso,
  output logic [CS_W-1:0] cs_n
);
  logic [15:0]       ctrl_q;
  logic              en_q;
  logic [31:0]       dly_q;
  logic [STS_W-1:0]  mask_q;
  logic              sts_txov, sts_rxov;
  logic [STS_W-1:0]  sts_vec;

  logic              wr_ctrl, wr_sts, wr_mset, wr_mclr, wr_en_reg, wr_dly, wr_txd, rd_rxd;
  logic              txov_clr, rxov_clr;
  logic              tx_push, tx_pop, tx_full, tx_empty;
  logic              rx_push, rx_pop, rx_full, rx_empty;
  logic [DATA_W-1:0] tx_head, rx_head, eng_rx;
  logic              eng_start, eng_busy, eng_done, run_ok;
  logic              cfg_cpol, cfg_cpha;
  logic [DIV_W-1:0]  cfg_div;

  // Register decode
  assign wr_ctrl   = wr_en && (addr == OFS_CTRL);
  assign wr_sts    = wr_en && (addr == OFS_STS);
  assign wr_mset   = wr_en && (addr == OFS_MSET);
  assign wr_mclr   = wr_en && (addr == OFS_MCLR);
  assign wr_en_reg = wr_en && (addr == OFS_EN);
  assign wr_dly    = wr_en && (addr == OFS_DLY);
  assign wr_txd    = wr_en && (addr == OFS_TXD);
  assign rd_rxd    = rd_en && (addr == OFS_RXD);
  assign txov_clr  = wr_sts && wdata[SB_TXOV];
  assign rxov_clr  = wr_sts && wdata[SB_RXOV];

  // Configuration fields
  assign cfg_cpol = ctrl_q[CB_CPOL];
  assign cfg_cpha = ctrl_q[CB_CPHA];
  assign cfg_div  = ctrl_q[CB_DIV_LO +: DIV_W];
  assign cs_n     = ctrl_q[CB_CS_LO +: CS_W];

  // Auto start
  assign run_ok    = en_q && ctrl_q[CB_MASTER] && !ctrl_q[CB_MSTART];
  assign eng_start = run_ok && !tx_empty && !eng_busy;
  assign tx_pop    = eng_start;
  assign tx_push   = wr_txd && !tx_full;
  assign rx_push   = eng_done && !rx_full;
  assign rx_pop    = rd_rxd && !rx_empty;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q   <= CTRL_RST;
      en_q     <= 1'b0;
      dly_q    <= '0;
      mask_q   <= '0;
      sts_txov <= 1'b0;
      sts_rxov <= 1'b0;
    end else begin
      if (wr_ctrl)   ctrl_q <= wdata[15:0];
      if (wr_en_reg) en_q   <= wdata[0];
      if (wr_dly)    dly_q  <= wdata;
      if (wr_mset)   mask_q <= mask_q | wdata[STS_W-1:0];
      else if (wr_mclr) mask_q <= mask_q & ~wdata[STS_W-1:0];
      // a new event in the same cycle wins over the clear
      if (wr_txd && tx_full)     sts_txov <= 1'b1;
      else if (txov_clr)         sts_txov <= 1'b0;
      if (eng_done && rx_full)   sts_rxov <= 1'b1;
      else if (rxov_clr)         sts_rxov <= 1'b0;
    end
  end

  always_comb begin
    sts_vec          = '0;
    sts_vec[SB_TXOV] = sts_txov;
    sts_vec[SB_RXOV] = sts_rxov;
    sts_vec[SB_TXNF] = !tx_full;
    sts_vec[SB_RXNE] = !rx_empty;
  end

  assign irq = |(sts_vec & mask_q);

  always_comb begin
    rdata = '0;
    case (addr)
      OFS_CTRL: rdata[15:0]      = ctrl_q;
      OFS_STS:  rdata[STS_W-1:0] = sts_vec;
      OFS_MASK: rdata[STS_W-1:0] = mask_q;
      OFS_EN:   rdata[0]         = en_q;
      OFS_DLY:  rdata            = dly_q;
      OFS_RXD:  rdata[DATA_W-1:0] = rx_empty ? '0 : rx_head;
      default:  rdata = '0;
    endcase
  end

  spi_fm_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(DATA_W)) u_txq (
    .clk(clk), .rst_n(rst_n), .push(tx_push), .din(wdata[DATA_W-1:0]),
    .pop(tx_pop), .head(tx_head), .full(tx_full), .empty(tx_empty)
  );

  spi_fm_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(DATA_W)) u_rxq (
    .clk(clk), .rst_n(rst_n), .push(rx_push), .din(eng_rx),
    .pop(rx_pop), .head(rx_head), .full(rx_full), .empty(rx_empty)
  );

  spi_fm_engine #(.DATA_W(DATA_W), .DIV_W(DIV_W)) u_eng (
    .clk(clk), .rst_n(rst_n), .start(eng_start), .tx_byte(tx_head),
    .cpol(cfg_cpol), .cpha(cfg_cpha), .div_code(cfg_div), .miso(miso),
    .sclk(sclk), .mosi(mosi), .busy(eng_busy), .done(eng_done), .rx_byte(eng_rx)
  );
endmodule

// File: rtl/spi_fm_checker.sv
module spi_fm_checker (
  input logic clk,
  input logic rst_n,
  input logic sclk,
  input logic cpol,
  input logic busy,
  input logic start,
  input logic tx_pop,
  input logic tx_empty,
  input logic done,
  input logic rx_full,
  input logic rx_push,
  input logic rxov,
  input logic rxov_clr
);
  AST_SCLK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (sclk == cpol)); // R4

  AST_START_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy); // R2

  AST_POP_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    tx_pop |-> !tx_empty); // R2

  AST_DONE_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !rx_full) |-> rx_push); // R6

  AST_RXOV_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (rxov && !rxov_clr) |=> rxov); // R10

  AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(busy)); // R5
endmodule

bind spi_fifo_master spi_fm_checker u_chk (
  .clk(clk), .rst_n(rst_n), .sclk(sclk), .cpol(cfg_cpol), .busy(eng_busy),
  .start(eng_start), .tx_pop(tx_pop), .tx_empty(tx_empty), .done(eng_done),
  .rx_full(rx_full), .rx_push(rx_push), .rxov(sts_rxov), .rxov_clr(rxov_clr)
);

// File: tb/tb_spi_fifo_master.sv
`timescale 1ns/1ps
module tb_spi_fifo_master;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq, sclk, mosi, miso;
  logic [3:0]  cs_n;
  logic        inv = 1'b0;

  int n_chk = 0, n_bad = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;
  assign miso = mosi ^ inv;

  spi_fifo_master #(.FIFO_DEPTH(4)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq(irq), .sclk(sclk), .mosi(mosi),
    .miso(miso), .cs_n(cs_n)
  );

  // Bus-side slave monitor
  logic       mon_en = 1'b0, t_cpol = 1'b0, t_cpha = 1'b0;
  int         exp_half = 1;
  logic       prev_sclk;
  int         mon_cnt, mon_edges, mon_bits, mon_n, mon_bad_iv;
  logic [7:0] mon_sr;
  logic [7:0] mon_q [16];

  always @(negedge clk) begin
    if (!mon_en) begin
      mon_cnt = 0; mon_edges = 0; mon_bits = 0; mon_n = 0; mon_bad_iv = 0;
      mon_sr = '0;
    end else if (sclk !== prev_sclk) begin
      if ((mon_edges % 16) != 0 && mon_cnt != exp_half) mon_bad_iv++;
      mon_cnt = 1;
      mon_edges++;
      if ((sclk != t_cpol) ^ t_cpha) begin
        mon_sr = {mon_sr[6:0], mosi};
        mon_bits++;
        if (mon_bits == 8) begin
          if (mon_n < 16) mon_q[mon_n] = mon_sr;
          mon_n++;
          mon_bits = 0;
        end
      end
    end else begin
      mon_cnt++;
    end
    prev_sclk = sclk;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic bus_rd(input logic [7:0] a, input bit pop, output logic [31:0] d);
    @(negedge clk);
    addr = a; rd_en = pop;
    #1 d = rdata;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic int byte_time(input int code, input int n);
    return n * (16 * (1 << code) + 2) + 8;
  endfunction

  function automatic logic [31:0] ctrl_word(input int code, input bit cpol, input bit cpha,
                                            input logic [3:0] cs, input bit mstart, input bit master);
    return (32'(mstart) << 15) | (32'(cs) << 10) | (32'(code) << 3) |
           (32'(cpha) << 2) | (32'(cpol) << 1) | 32'(master);
  endfunction

  task automatic set_cfg(input int code, input bit cpol, input bit cpha);
    mon_en = 1'b0;
    t_cpol = cpol; t_cpha = cpha; exp_half = 1 << code;
    bus_wr(8'h00, ctrl_word(code, cpol, cpha, 4'b1110, 1'b0, 1'b1));
    idle(2);
    mon_en = 1'b1;
  endtask

  logic [31:0] rv;
  logic [7:0]  tb_bytes [6];

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(2);

    // R1: reset state
    bus_rd(8'h00, 0, rv); chk(rv == 32'h3C00, "R1 ctrl", rv, 32'h3C00);
    bus_rd(8'h04, 0, rv); chk(rv == 32'h04, "R1 status", rv, 32'h04);
    bus_rd(8'h10, 0, rv); chk(rv == 32'h0, "R1 mask", rv, 32'h0);
    chk(cs_n == 4'hF && sclk == 1'b0 && irq == 1'b0, "R1 pins",
        {27'b0, irq, cs_n}, 32'h0F);

    // R7: chip-select pins mirror field
    foreach (tb_bytes[k]) tb_bytes[k] = '0;
    for (int f = 0; f < 16; f++) begin
      bus_wr(8'h00, ctrl_word(0, 0, 0, 4'(f), 0, 1));
      idle(1);
      chk(cs_n == 4'(f), "R7 cs_n", 32'(cs_n), 32'(f));
    end

    // Mode/divider sweep with direct and inverted loopback (R3 R4 R5 R6)
    bus_wr(8'h14, 32'h1);
    for (int code = 0; code < 8; code++) begin
      if (code > 3 && code != 7) continue;
      for (int m = 0; m < 4; m++) begin
        logic [7:0] b0, b1;
        b0 = 8'(8'hA5 ^ (code * 29 + m * 7));
        b1 = 8'(8'h3C + code * 17 + m * 41);
        inv = m[0] ^ code[0];
        set_cfg(code, m[1], m[0]);
        chk(sclk == m[1], "R4 idle level before", 32'(sclk), 32'(m[1]));
        bus_wr(8'h1C, {24'h0, b0});
        bus_wr(8'h1C, {24'h0, b1});
        idle(byte_time(code, 2));
        chk(sclk == m[1], "R4 idle level after", 32'(sclk), 32'(m[1]));
        chk(mon_bad_iv == 0, "R3 half period", 32'(mon_bad_iv), 32'h0);
        chk(mon_edges == 32, "R5 edge count", 32'(mon_edges), 32'd32);
        chk(mon_n == 2 && mon_q[0] == b0 && mon_q[1] == b1, "R5 msb first",
            {mon_q[0], mon_q[1]}, {b0, b1});
        bus_rd(8'h20, 1, rv);
        chk(rv == {24'h0, b0 ^ {8{inv}}}, "R6 rx byte 0", rv, {24'h0, b0 ^ {8{inv}}});
        bus_rd(8'h20, 1, rv);
        chk(rv == {24'h0, b1 ^ {8{inv}}}, "R6 rx byte 1", rv, {24'h0, b1 ^ {8{inv}}});
        bus_rd(8'h04, 0, rv);
        chk(rv[4] == 1'b0, "R9 rx empty after drain", rv, 32'h04);
      end
    end
    inv = 1'b0;

    // R12: only low byte of the write is queued
    set_cfg(0, 0, 0);
    bus_wr(8'h1C, 32'hABCD_125A);
    idle(byte_time(0, 1));
    bus_rd(8'h20, 1, rv);
    chk(rv == 32'h5A, "R12 low byte", rv, 32'h5A);

    // R2: blocked start conditions
    bus_wr(8'h14, 32'h0);
    set_cfg(0, 0, 0);
    bus_wr(8'h1C, 32'h11);
    idle(60);
    chk(mon_edges == 0, "R2 enable clear", 32'(mon_edges), 0);
    bus_wr(8'h00, ctrl_word(0, 0, 0, 4'b1110, 1, 1));
    bus_wr(8'h14, 32'h1);
    idle(60);
    chk(mon_edges == 0, "R2 manual start set", 32'(mon_edges), 0);
    bus_wr(8'h00, ctrl_word(0, 0, 0, 4'b1110, 0, 0));
    idle(60);
    chk(mon_edges == 0, "R2 master clear", 32'(mon_edges), 0);
    bus_rd(8'h04, 0, rv);
    chk(rv[4] == 1'b0, "R2 nothing received", rv, 32'h04);
    bus_wr(8'h00, ctrl_word(0, 0, 0, 4'b1110, 0, 1));
    idle(byte_time(0, 1));
    bus_rd(8'h20, 1, rv);
    chk(rv == 32'h11 && mon_n == 1, "R2 starts once allowed", rv, 32'h11);

    // R8/R11/R10: transmit overflow, mask, clear
    bus_wr(8'h14, 32'h0);
    for (int i = 0; i < 5; i++) begin
      tb_bytes[i] = 8'(8'h61 + i * 3);
      bus_wr(8'h1C, {24'h0, tb_bytes[i]});
    end
    bus_rd(8'h04, 0, rv);
    chk(rv[0] == 1'b1 && rv[2] == 1'b0, "R8 tx overflow flag", rv, 32'h01);
    chk(irq == 1'b0, "R11 masked irq", 32'(irq), 0);
    bus_wr(8'h08, 32'h1);
    bus_rd(8'h10, 0, rv);
    chk(rv == 32'h1, "R11 mask set", rv, 32'h1);
    chk(irq == 1'b1, "R11 irq raised", 32'(irq), 1);
    bus_wr(8'h0C, 32'h1);
    bus_rd(8'h10, 0, rv);
    chk(rv == 32'h0 && irq == 1'b0, "R11 mask clear", rv, 32'h0);
    bus_wr(8'h04, 32'h0);
    bus_rd(8'h04, 0, rv);
    chk(rv[0] == 1'b1, "R10 write zero keeps", rv, 32'h01);
    bus_wr(8'h04, 32'h1);
    bus_rd(8'h04, 0, rv);
    chk(rv[0] == 1'b0, "R10 write one clears", rv, 32'h04);

    // R9: receive overflow
    bus_wr(8'h14, 32'h1);
    idle(byte_time(0, 4));
    bus_wr(8'h1C, 32'h77);
    bus_wr(8'h1C, 32'h78);
    idle(byte_time(0, 2));
    bus_rd(8'h04, 0, rv);
    chk(rv[1] == 1'b1 && rv[4] == 1'b1, "R9 rx overflow flag", rv, 32'h16);
    for (int i = 0; i < 4; i++) begin
      bus_rd(8'h20, 1, rv);
      chk(rv == {24'h0, tb_bytes[i]}, "R9 kept oldest bytes", rv, {24'h0, tb_bytes[i]});
    end
    bus_rd(8'h04, 0, rv);
    chk(rv[4] == 1'b0, "R9 extra bytes dropped", rv, 32'h06);
    bus_wr(8'h04, 32'h2);
    bus_rd(8'h04, 0, rv);
    chk(rv[1] == 1'b0, "R10 rx overflow cleared", rv, 32'h04);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule